// File: doc/BRIEF.md
# Ripple-Chained Bit-Slice ALU with Signed Compare

This block is a combinational integer ALU of parameterised width. It is built as a chain of identical one-bit cells with a dedicated top cell. Every cell conditions its two operand bits, because either bit can be replaced by its complement. From the conditioned bits the cell forms the AND, the OR and a full-adder sum all at once. A two-bit selector then chooses one of these as the cell's result, or chooses an externally supplied "less" bit. The carry ripples from each cell into the next. There is no lookahead.

A single negate control both complements the b operand in every cell and feeds the carry into bit 0, so the add path yields a - b. The top cell exports the sign of its sum. That bit is wired back to the "less" input of bit 0, while all other cells see 0, which gives a 0/1 compare result. Selecting AND while both operands are complemented yields NOR. The block also reports a zero flag, the adder carry-out and signed overflow. The block has no clock and no state, and no data handshake: the outputs settle from the inputs alone.

Top module: `bitslice_alu`

## Requirements
- R1: When `a_invert_i` is 1 every bit of a is complemented before use, and when `b_negate_i` is 1 every bit of b is complemented before use (the conditioned operands A and B).
- R2: `op_sel_i` = 2'b00 gives result = A AND B, and `op_sel_i` = 2'b01 gives result = A OR B.
- R3: `op_sel_i` = 2'b10 gives result = (A + B + `b_negate_i`) truncated to WIDTH bits. With `a_invert_i`=0 and `b_negate_i`=1 this equals a - b modulo 2^WIDTH.
- R4: `carry_o` is the carry out of the top bit of A + B + `b_negate_i`, whatever `op_sel_i` is.
- R5: `overflow_o` is the XOR of the carry into the top bit and the carry out of the top bit of that same addition.
- R6: `op_sel_i` = 2'b11 gives result bit 0 = top bit of A + B + `b_negate_i`, with every other bit 0. Under {a_invert,b_negate,op}=4'b0111 this is the sign of the wrapped difference a - b.
- R7: With `a_invert_i`=1, `b_negate_i`=1 and `op_sel_i`=2'b00 the result is NOT (a OR b).
- R8: `zero_o` is 1 exactly when all result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| a_invert_i | input | 1 | Complement a before use |
| b_negate_i | input | 1 | Complement b and set carry into bit 0 |
| op_sel_i | input | 2 | 00 AND, 01 OR, 10 add, 11 less |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out of the top bit |
| overflow_o | output | 1 | Signed overflow of the addition |

## Verification
The embedded checks assume the inputs carry only known 0/1 values and are read once the ripple chain has settled. The bench therefore changes inputs on one clock edge and samples half a period later. The narrow configuration is swept over every operand pair and every control combination, so every selector and inversion pairing is covered. The wide configuration receives only the edge operands: zero, all ones, most negative and most positive.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_ADD  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import bitslice_alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_invert_i,
  input  logic    b_invert_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    result_o,
  output logic    sum_o,
  output logic    carry_o
);
  logic a_c, b_c;

  // R1: operand conditioning
  assign a_c = a_invert_i ? ~a_i : a_i;
  assign b_c = b_invert_i ? ~b_i : b_i;

  // full adder, majority carry
  assign sum_o   = a_c ^ b_c ^ carry_i;
  assign carry_o = (a_c & b_c) | (a_c & carry_i) | (b_c & carry_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  result_o = a_c & b_c;
      OP_OR:   result_o = a_c | b_c;
      OP_ADD:  result_o = sum_o;
      default: result_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import bitslice_alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    a_invert_i,
  input  logic    b_invert_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    result_o,
  output logic    set_o,
  output logic    carry_o,
  output logic    overflow_o
);
  logic sum_w;

  alu_bit_slice u_core (
    .a_i        (a_i),
    .b_i        (b_i),
    .a_invert_i (a_invert_i),
    .b_invert_i (b_invert_i),
    .carry_i    (carry_i),
    .less_i     (less_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .sum_o      (sum_w),
    .carry_o    (carry_o)
  );

  assign set_o      = sum_w;
  assign overflow_o = carry_i ^ carry_o;  // R5
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);
  assign zero_o = ~(|value_i);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bitslice_alu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_invert_i,
  input  logic             b_negate_i,
  input  logic [1:0]       op_sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             overflow_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op_w;
  logic [WIDTH:0]   chain_w;
  logic [WIDTH-1:0] res_w;
  logic             set_w;

  assign op_w       = alu_op_e'(op_sel_i);
  assign chain_w[0] = b_negate_i;  // negate feeds carry into bit 0 (R3)

  generate
    for (genvar i = 0; i < MSB; i++) begin : g_slice
      alu_bit_slice u_slice (
        .a_i        (a_i[i]),
        .b_i        (b_i[i]),
        .a_invert_i (a_invert_i),
        .b_invert_i (b_negate_i),
        .carry_i    (chain_w[i]),
        .less_i     ((i == 0) ? set_w : 1'b0),  // R6 feedback
        .op_i       (op_w),
        .result_o   (res_w[i]),
        .sum_o      (),
        .carry_o    (chain_w[i+1])
      );
    end
  endgenerate

  alu_msb_slice u_top (
    .a_i        (a_i[MSB]),
    .b_i        (b_i[MSB]),
    .a_invert_i (a_invert_i),
    .b_invert_i (b_negate_i),
    .carry_i    (chain_w[MSB]),
    .less_i     (1'b0),
    .op_i       (op_w),
    .result_o   (res_w[MSB]),
    .set_o      (set_w),
    .carry_o    (chain_w[WIDTH]),
    .overflow_o (overflow_o)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value_i (res_w),
    .zero_o  (zero_o)
  );

  assign result_o = res_w;
  assign carry_o  = chain_w[WIDTH];

  // embedded checks, relating ports to the slice chain's output
  always_comb begin
    if (!a_invert_i && !b_negate_i && op_sel_i == 2'b00)
      p_and_plain_r2: assert (result_o == (a_i & b_i));
    if (!a_invert_i && !b_negate_i && op_sel_i == 2'b01)
      p_or_plain_r2: assert (result_o == (a_i | b_i));
    if (!a_invert_i && b_negate_i && op_sel_i == 2'b10)
      p_subtract_r3: assert (result_o == WIDTH'(a_i - b_i));
    if (!a_invert_i && !b_negate_i)
      p_add_carry_r4: assert ({carry_o, a_i + b_i} == ({1'b0, a_i} + {1'b0, b_i}));
    if (!a_invert_i && !b_negate_i && (a_i[MSB] != b_i[MSB]))
      p_no_overflow_r5: assert (!overflow_o);
    if (op_sel_i == 2'b11)
      p_less_upper_r6: assert (result_o[MSB:1] == '0);
    if (a_invert_i && b_negate_i && op_sel_i == 2'b00)
      p_nor_r7: assert (result_o == ~(a_i | b_i));
    if (zero_o)
      p_zero_result_r8: assert (result_o == '0);
  end
endmodule

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  localparam int NW = 4;
  localparam int WW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [NW-1:0] na, nb, nres;
  logic [WW-1:0] wa, wb, wres;
  logic ainv, bneg;
  logic [1:0] op;
  logic nz, nc, nv, wz, wc, wv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bitslice_alu #(.WIDTH(NW)) dut_i (
    .a_i(na), .b_i(nb), .a_invert_i(ainv), .b_negate_i(bneg), .op_sel_i(op),
    .result_o(nres), .zero_o(nz), .carry_o(nc), .overflow_o(nv)
  );

  bitslice_alu #(.WIDTH(WW)) dut_w_i (
    .a_i(wa), .b_i(wb), .a_invert_i(ainv), .b_negate_i(bneg), .op_sel_i(op),
    .result_o(wres), .zero_o(wz), .carry_o(wc), .overflow_o(wv)
  );

  // arithmetic reference: returns {ovf, carry, zero, result} in 67 bits
  function automatic logic [66:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic ai, input logic bn,
                                        input logic [1:0] o, input int w);
    logic [64:0] mask, ac, bc, sum, low, res;
    logic cout, cin_top, ovf;
    mask = (65'd1 << w) - 65'd1;
    ac   = (ai ? ~{1'b0, a} : {1'b0, a}) & mask;  // R1
    bc   = (bn ? ~{1'b0, b} : {1'b0, b}) & mask;
    sum  = ac + bc + {64'd0, bn};
    cout = sum[w];
    low  = (ac & (mask >> 1)) + (bc & (mask >> 1)) + {64'd0, bn};
    cin_top = low[w-1];
    ovf  = cin_top ^ cout;
    case (o)
      2'b00:   res = ac & bc;
      2'b01:   res = ac | bc;
      2'b10:   res = sum & mask;
      default: res = {64'd0, sum[w-1]};
    endcase
    model = {ovf, cout, ((res & mask) == 65'd0), res[63:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ainv=%0b bneg=%0b op=%0b got=%h exp=%h", tag, ainv, bneg, op, got, exp);
    end
  endtask

  task automatic check_narrow();
    logic [66:0] m;
    m = model({60'd0, na}, {60'd0, nb}, ainv, bneg, op, NW);
    check(op[1] ? (op[0] ? "R6" : "R3") : (ainv && bneg && !op[0] ? "R7" : "R2"),
          {60'd0, nres}, m[63:0]);
    check("R8", {63'd0, nz}, {63'd0, m[64]});
    check("R4", {63'd0, nc}, {63'd0, m[65]});
    check("R5", {63'd0, nv}, {63'd0, m[66]});
  endtask

  task automatic check_wide();
    logic [66:0] m;
    m = model(wa, wb, ainv, bneg, op, WW);
    check(op == 2'b11 ? "R6" : "R1", wres, m[63:0]);
    check("R8", {63'd0, wz}, {63'd0, m[64]});
    check("R4", {63'd0, wc}, {63'd0, m[65]});
    check("R5", {63'd0, wv}, {63'd0, m[66]});
  endtask

  initial begin
    logic [63:0] edges [4];
    edges[0] = 64'd0;
    edges[1] = '1;
    edges[2] = 64'h8000_0000_0000_0000;
    edges[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    na = '0; nb = '0; wa = '0; wb = '0; ainv = 0; bneg = 0; op = 2'b00;
    @(posedge clk); #1;
    // reset-like start: 0 AND 0 is zero with flag set (R8)
    check("R8", {63'd0, nz}, 64'd1);
    check("R2", {60'd0, nres}, 64'd0);
    for (int c = 0; c < 16; c++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(negedge clk);
          {ainv, bneg, op} = 4'(c);
          na = 4'(x); nb = 4'(y);
          @(posedge clk); #1;
          check_narrow();
        end
      end
    end
    for (int c = 0; c < 16; c++) begin
      for (int x = 0; x < 4; x++) begin
        for (int y = 0; y < 4; y++) begin
          @(negedge clk);
          {ainv, bneg, op} = 4'(c);
          wa = edges[x]; wb = edges[y];
          @(posedge clk); #1;
          check_wide();
        end
      end
    end
    // directed: 3 - 5 less-than in narrow view (R6), 7 + 1 overflow (R5)
    @(negedge clk); {ainv, bneg, op} = 4'b0111; na = 4'd3; nb = 4'd5;
    @(posedge clk); #1; check("R6", {60'd0, nres}, 64'd1);
    @(negedge clk); {ainv, bneg, op} = 4'b0010; na = 4'd7; nb = 4'd1;
    @(posedge clk); #1; check("R5", {63'd0, nv}, 64'd1);
    check("R3", {60'd0, nres}, 64'd8);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule